// File: doc/BRIEF.md
# Serial Unlock Pattern Recognizer

This block watches a stream of abstracted bus cycles aimed at a memory socket and looks for a fixed 64-bit key. The key arrives one bit per write cycle on data line 0. A read cycle arms the search by moving the bit pointer back to the first key bit. Each write whose data bit equals the expected key bit moves the pointer forward. The first write that disagrees parks the pointer, and every later write is ignored until another read re-arms it. Until the whole key has been seen, every cycle belongs to the memory, including the key writes themselves.

When the 64th consecutive matching write arrives, the block enters clock-access mode. It raises `unlocked` and drops `mem_enable`, which hands the bus to a serial transfer engine. The engine answers with a one-cycle `xfer_done` pulse when its transfer finishes or aborts. That pulse relocks the recognizer and returns it to an armed state at key bit 0. Cycles in which the part is not selected pass by without touching the search.

Top module: `unlock_recognizer`

## Requirements
- R1: While `rst_n` is low and right after it is released, `unlocked` is 0, `mem_enable` is 1, and the recognizer is armed at key bit 0, so a complete key with no preceding read unlocks it.
- R2: Key bit i (i = 0..63) is bit (i mod 8) of byte (i div 8). The bytes, in order 0 to 7, are C5, 3A, A3, 5C, C5, 3A, A3, 5C. Bit 0 of a byte is its least significant bit. Only `cyc_d0` of a write is compared.
- R3: A selected write (`cyc_valid`=1, `cyc_sel`=1, `cyc_write`=1) whose `cyc_d0` equals the key bit at the pointer advances the pointer by one. After 63 matching writes `unlocked` is still 0. It becomes 1 in the cycle after the event of the 64th matching write. Idle cycles (`cyc_valid`=0) between key writes do not matter.
- R4: A selected write whose `cyc_d0` differs from the expected key bit leaves the pointer where it is. All following writes are then ignored, even a complete correct key, until a read arrives.
- R5: A selected read (`cyc_write`=0) returns the pointer to bit 0 and clears a mismatch, aborting any partial attempt.
- R6: A cycle with `cyc_sel`=0 has no effect on the pointer or on the mismatch state, whatever its direction or data.
- R7: `mem_enable` is 1 whenever `unlocked` is 0. Every cycle the recognizer acts on, the key writes included, occurs while `mem_enable` is 1.
- R8: While `unlocked` is 1, bus cycles do not affect the recognizer and `unlocked` stays 1. A one-cycle `xfer_done` makes `unlocked` 0 and `mem_enable` 1 in the next cycle, with the recognizer armed at key bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_valid | input | 1 | One bus cycle event this clock |
| cyc_write | input | 1 | 1 = write cycle, 0 = read cycle |
| cyc_sel | input | 1 | Part selected during this cycle |
| cyc_d0 | input | 1 | Data line 0 of the cycle |
| xfer_done | input | 1 | Transfer engine finished or aborted (one-cycle pulse) |
| unlocked | output | 1 | Clock-access mode active |
| mem_enable | output | 1 | Memory may take bus cycles |

## Verification
The assertions assume that each bus cycle appears as a single-clock `cyc_valid` event. They also assume that `xfer_done` arrives only as a one-cycle pulse. The bench holds to this: each cycle is one clock of `cyc_valid` driven on the falling edge, and idle gaps are clocks with `cyc_valid` low. `xfer_done` is raised only after an unlock, for exactly one clock and with no bus cycle in the same clock. The stimulus covers every direction, selection and data combination that reaches the decoder.

// File: rtl/unlock_pkg.sv
package unlock_pkg;

  localparam int unsigned KEY_BITS_DEFAULT = 64;

  // Byte 0 sits in the least significant byte; bit i of the vector is key bit i.
  localparam logic [KEY_BITS_DEFAULT-1:0] KEY_DEFAULT = 64'h5CA3_3AC5_5CA3_3AC5;

  typedef enum logic [1:0] {
    CYC_NONE  = 2'd0,
    CYC_READ  = 2'd1,
    CYC_WRITE = 2'd2
  } cyc_kind_e;

  // Classify one bus event; unselected or absent cycles carry no meaning here.
  function automatic cyc_kind_e classify_cycle(input logic valid,
                                               input logic sel,
                                               input logic write);
    if (!(valid && sel)) return CYC_NONE;
    return write ? CYC_WRITE : CYC_READ;
  endfunction

endpackage

// File: rtl/unlock_cycle_decode.sv
module unlock_cycle_decode
  import unlock_pkg::*;
(
  input  logic cyc_valid,
  input  logic cyc_write,
  input  logic cyc_sel,
  input  logic unlocked,
  input  logic xfer_done,
  output logic evt_read,
  output logic evt_write
);

  cyc_kind_e kind;
  logic      listening;

  assign kind      = classify_cycle(cyc_valid, cyc_sel, cyc_write);
  // Cycles during clock-access mode, or in the relock clock, belong to the engine.
  assign listening = !unlocked && !xfer_done;
  assign evt_read  = listening && (kind == CYC_READ);
  assign evt_write = listening && (kind == CYC_WRITE);

endmodule

// File: rtl/unlock_key_select.sv
module unlock_key_select #(
  parameter int unsigned              KEY_BITS    = 64,
  parameter logic [KEY_BITS-1:0]      KEY_PATTERN = '0,
  localparam int unsigned             PTR_W       = $clog2(KEY_BITS)
) (
  input  logic [PTR_W-1:0] ptr,
  input  logic             d0,
  output logic             key_match
);

  logic [KEY_BITS-1:0] bit_hit;

  generate
    for (genvar g = 0; g < KEY_BITS; g++) begin : g_bit
      assign bit_hit[g] = (ptr == PTR_W'(g)) && (d0 == KEY_PATTERN[g]);
    end
  endgenerate

  assign key_match = |bit_hit;

endmodule

// File: rtl/unlock_seq_ptr.sv
module unlock_seq_ptr #(
  parameter int unsigned  KEY_BITS = 64,
  localparam int unsigned PTR_W    = $clog2(KEY_BITS),
  localparam logic [PTR_W-1:0] LAST = PTR_W'(KEY_BITS - 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             evt_read,
  input  logic             evt_write,
  input  logic             key_match,
  output logic [PTR_W-1:0] ptr,
  output logic             frozen,
  output logic             hit_last
);

  logic step;

  function automatic logic [PTR_W-1:0] advance(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + PTR_W'(1);
  endfunction

  assign step     = evt_write && !frozen && key_match;
  assign hit_last = step && (ptr == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr    <= '0;
      frozen <= 1'b0;
    end else if (clear || evt_read) begin
      ptr    <= '0;
      frozen <= 1'b0;
    end else if (evt_write && !frozen) begin
      if (key_match) ptr    <= advance(ptr);
      else           frozen <= 1'b1;
    end
  end

endmodule

// File: rtl/unlock_mode_reg.sv
module unlock_mode_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic hit_last,
  input  logic xfer_done,
  output logic unlocked
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         unlocked <= 1'b0;
    else if (xfer_done) unlocked <= 1'b0;
    else if (hit_last)  unlocked <= 1'b1;
  end

endmodule

// File: rtl/unlock_recognizer.sv
module unlock_recognizer #(
  parameter int unsigned          KEY_BITS    = unlock_pkg::KEY_BITS_DEFAULT,
  parameter logic [KEY_BITS-1:0]  KEY_PATTERN = unlock_pkg::KEY_DEFAULT,
  localparam int unsigned         PTR_W       = $clog2(KEY_BITS)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cyc_valid,
  input  logic cyc_write,
  input  logic cyc_sel,
  input  logic cyc_d0,
  input  logic xfer_done,
  output logic unlocked,
  output logic mem_enable
);

  logic             evt_read;
  logic             evt_write;
  logic             key_match;
  logic             hit_last;
  logic             frozen;
  logic [PTR_W-1:0] ptr;

  unlock_cycle_decode i_decode (
    .cyc_valid (cyc_valid),
    .cyc_write (cyc_write),
    .cyc_sel   (cyc_sel),
    .unlocked  (unlocked),
    .xfer_done (xfer_done),
    .evt_read  (evt_read),
    .evt_write (evt_write)
  );

  unlock_key_select #(
    .KEY_BITS    (KEY_BITS),
    .KEY_PATTERN (KEY_PATTERN)
  ) i_key (
    .ptr       (ptr),
    .d0        (cyc_d0),
    .key_match (key_match)
  );

  unlock_seq_ptr #(
    .KEY_BITS (KEY_BITS)
  ) i_ptr (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (xfer_done),
    .evt_read  (evt_read),
    .evt_write (evt_write),
    .key_match (key_match),
    .ptr       (ptr),
    .frozen    (frozen),
    .hit_last  (hit_last)
  );

  unlock_mode_reg i_mode (
    .clk       (clk),
    .rst_n     (rst_n),
    .hit_last  (hit_last),
    .xfer_done (xfer_done),
    .unlocked  (unlocked)
  );

  assign mem_enable = !unlocked;

endmodule

// File: rtl/unlock_recognizer_chk.sv
module unlock_recognizer_chk #(
  parameter int unsigned PTR_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cyc_valid,
  input logic             cyc_sel,
  input logic             xfer_done,
  input logic             unlocked,
  input logic             mem_enable,
  input logic             evt_read,
  input logic             evt_write,
  input logic             key_match,
  input logic             hit_last,
  input logic             frozen,
  input logic [PTR_W-1:0] ptr
);

  // R5
  read_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_read |=> (ptr == '0) && !frozen);

  // R4
  mismatch_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_write && !frozen && !key_match) |=> frozen);

  // R4
  frozen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen && !evt_read && !xfer_done) |=> (frozen && $stable(ptr)));

  // R3
  advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_write && !frozen && key_match && !hit_last) |=> (ptr == $past(ptr) + PTR_W'(1)));

  // R3
  unlock_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlocked) |-> $past(hit_last));

  // R6
  unselected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && !cyc_sel && !xfer_done) |=> ($stable(ptr) && $stable(frozen)));

  // R7
  mem_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_read || evt_write) |-> mem_enable);

  // R8
  done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> (!unlocked && mem_enable && (ptr == '0) && !frozen));

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (unlocked && !xfer_done) |=> unlocked);

endmodule

bind unlock_recognizer unlock_recognizer_chk #(.PTR_W(PTR_W)) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cyc_valid  (cyc_valid),
  .cyc_sel    (cyc_sel),
  .xfer_done  (xfer_done),
  .unlocked   (unlocked),
  .mem_enable (mem_enable),
  .evt_read   (evt_read),
  .evt_write  (evt_write),
  .key_match  (key_match),
  .hit_last   (hit_last),
  .frozen     (frozen),
  .ptr        (ptr)
);

// File: tb/test_unlock_recognizer.sv
module test_unlock_recognizer;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cyc_valid = 1'b0;
  logic cyc_write = 1'b0;
  logic cyc_sel = 1'b0;
  logic cyc_d0 = 1'b0;
  logic xfer_done = 1'b0;
  logic unlocked;
  logic mem_enable;

  int n_checks = 0;
  int n_errors = 0;
  int n_cycles = 0;

  localparam logic [7:0] KEY_BYTES [4] = '{8'hC5, 8'h3A, 8'hA3, 8'h5C};

  always #10 clk = ~clk;

  unlock_recognizer i_unlock_recognizer (
    .clk        (clk),
    .rst_n      (rst_n),
    .cyc_valid  (cyc_valid),
    .cyc_write  (cyc_write),
    .cyc_sel    (cyc_sel),
    .cyc_d0     (cyc_d0),
    .xfer_done  (xfer_done),
    .unlocked   (unlocked),
    .mem_enable (mem_enable)
  );

  always @(posedge clk) begin
    n_cycles++;
    if (n_cycles > 20000) begin
      n_errors++;
      $display("FAIL watchdog: actual %0d cycles expected under 20000", n_cycles);
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  // R2: key bit i is bit i%8 of byte i/8, the byte list repeating every four bytes.
  function automatic logic key_bit(input int i);
    return KEY_BYTES[(i / 8) % 4][i % 8];
  endfunction

  task automatic check(input string req, input string what, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
    end
  endtask

  task automatic cyc(input logic wr, input logic sel, input logic d0);
    cyc_valid = 1'b1;
    cyc_write = wr;
    cyc_sel   = sel;
    cyc_d0    = d0;
    @(negedge clk);
    cyc_valid = 1'b0;
    cyc_d0    = 1'b0;
  endtask

  task automatic send_bits(input int from, input int upto);
    for (int i = from; i <= upto; i++) cyc(1'b1, 1'b1, key_bit(i));
  endtask

  task automatic arm();
    cyc(1'b0, 1'b1, 1'b0);
  endtask

  task automatic release_engine(input string req);
    xfer_done = 1'b1;
    @(negedge clk);
    xfer_done = 1'b0;
    check(req, "unlocked after done", unlocked, 1'b0);
    check(req, "mem_enable after done", mem_enable, 1'b1);
  endtask

  task automatic t_reset();
    check("R1", "unlocked in reset", unlocked, 1'b0);
    check("R1", "mem_enable in reset", mem_enable, 1'b1);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "unlocked after reset", unlocked, 1'b0);
    check("R1", "mem_enable after reset", mem_enable, 1'b1);
  endtask

  task automatic t_full_key();
    // R1: armed at bit 0 from reset, no read needed. R2 key order.
    send_bits(0, 62);
    check("R3", "after 63 bits", unlocked, 1'b0);
    check("R7", "mem_enable during key", mem_enable, 1'b1);
    send_bits(63, 63);
    check("R2", "unlocked after 64 bits", unlocked, 1'b1);
    check("R7", "mem_enable when unlocked", mem_enable, 1'b0);
    release_engine("R8");
  endtask

  task automatic t_mismatch();
    arm();
    send_bits(0, 9);
    cyc(1'b1, 1'b1, ~key_bit(10));
    send_bits(10, 63);
    check("R4", "rest of key after mismatch", unlocked, 1'b0);
    send_bits(0, 63);
    check("R4", "full key while frozen", unlocked, 1'b0);
    arm();
    send_bits(0, 63);
    check("R5", "key after re-arm", unlocked, 1'b1);
    release_engine("R4");
  endtask

  task automatic t_read_abort();
    arm();
    send_bits(0, 39);
    arm();
    send_bits(40, 63);
    check("R5", "tail after read abort", unlocked, 1'b0);
    arm();
    send_bits(0, 63);
    check("R5", "full key after abort", unlocked, 1'b1);
    release_engine("R5");
  endtask

  task automatic t_unselected();
    arm();
    send_bits(0, 29);
    cyc(1'b0, 1'b0, 1'b0);
    cyc(1'b1, 1'b0, ~key_bit(30));
    @(negedge clk);
    cyc(1'b1, 1'b0, key_bit(30));
    cyc(1'b0, 1'b0, 1'b1);
    send_bits(30, 63);
    check("R6", "key with unselected cycles", unlocked, 1'b1);
    release_engine("R6");
  endtask

  task automatic t_idle_gaps();
    arm();
    for (int i = 0; i < 64; i++) begin
      cyc(1'b1, 1'b1, key_bit(i));
      if (i % 5 == 0) @(negedge clk);
    end
    check("R3", "key with idle gaps", unlocked, 1'b1);
    release_engine("R3");
  endtask

  task automatic t_unlocked_hold();
    arm();
    send_bits(0, 63);
    check("R8", "unlocked before engine cycles", unlocked, 1'b1);
    cyc(1'b1, 1'b1, 1'b0);
    cyc(1'b1, 1'b1, 1'b1);
    cyc(1'b0, 1'b1, 1'b0);
    cyc(1'b1, 1'b1, 1'b0);
    check("R8", "unlocked held", unlocked, 1'b1);
    check("R8", "mem_enable held low", mem_enable, 1'b0);
    release_engine("R8");
    // R8: after done the recognizer is armed at bit 0 without a read.
    send_bits(0, 63);
    check("R8", "rearmed by done", unlocked, 1'b1);
    release_engine("R8");
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_full_key();
    t_mismatch();
    t_read_abort();
    t_unselected();
    t_idle_gaps();
    t_unlocked_hold();
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule